// File: doc/BRIEF.md
# Packed Lane Minimum and Mask Unit

This unit works on 64-bit packed operands. A 16-bit opcode, sampled with a start strobe, selects one of three operations. The first is a lane-wise signed minimum over four 16-bit words. The second is a lane-wise unsigned minimum over eight bytes. The third collects the sign bit of every byte of the first operand into a zero-extended 32-bit mask.

Both operands arrive already resolved. The unit has no decode, register file or memory path. The two minimum operations take two clocks to finish. The mask operation takes one clock.

Completion is marked by a one-cycle done pulse. At that pulse the 64-bit result and the 32-bit mask are both written. Each output holds its value until the next completion.

Top module: `pmm_unit`

## Requirements
- R1: With opcode 0x0FEA, each 16-bit lane k (bits 16k+15:16k) of result_o holds lane k of a_i when that lane is strictly less than lane k of b_i as a signed value, and lane k of b_i otherwise.
- R2: With opcode 0x0FDA, each 8-bit lane k (bits 8k+7:8k) of result_o holds byte k of a_i when it is strictly less than byte k of b_i as an unsigned value, and byte k of b_i otherwise.
- R3: With opcode 0x0FD7, bit i of mask_o equals bit 8i+7 of a_i for i in 0..7, and bits 31:8 of mask_o are zero.
- R4: A minimum operation accepted at clock edge N raises done_o after edge N+1, and done_o stays low after edge N.
- R5: A mask operation accepted at edge N raises done_o after edge N, with mask_o valid in that same cycle.
- R6: The 16-bit op_i encodings are 0x0FEA for the signed word minimum, 0x0FDA for the unsigned byte minimum and 0x0FD7 for the mask extraction.
- R7: Any other op_i value at an accepted start makes result_o and mask_o zero and raises done_o after one clock.
- R8: A start that arrives while a minimum operation awaits its second clock is ignored. The pending result is delivered unchanged and no further done_o follows.
- R9: done_o lasts one cycle for each accepted start. result_o and mask_o change only in a cycle where done_o is high.
- R10: When rst_ni is low, result_o, mask_o and done_o are cleared and any pending operation is dropped.
- R11: A minimum completion writes mask_o to zero. A mask completion writes result_o to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled at the rising edge |
| op_i | input | 16 | Operation select |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| result_o | output | 64 | Packed minimum result |
| mask_o | output | 32 | Byte sign-bit mask |
| done_o | output | 1 | Completion pulse |

## Verification
The assertions assume that start_i, op_i and a_i carry known values at every clock edge once reset is released. They also assume that no start lands in the cycle that immediately follows reset release. The bench drives every input on the falling edge and keeps op_i at a defined value even when start_i is low. After reset it waits one full cycle before issuing the first start. A start during the pending cycle is driven on purpose to exercise the ignore rule.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
  parameter int OP_W = 16;
  localparam logic [OP_W-1:0] OP_SMINW = 16'h0FEA;
  localparam logic [OP_W-1:0] OP_UMINB = 16'h0FDA;
  localparam logic [OP_W-1:0] OP_MSKB  = 16'h0FD7;

  typedef enum logic [1:0] {K_SMINW, K_UMINB, K_MSKB, K_NONE} kind_e;

  function automatic kind_e decode_op(logic [OP_W-1:0] op);
    case (op)
      OP_SMINW: return K_SMINW;
      OP_UMINB: return K_UMINB;
      OP_MSKB:  return K_MSKB;
      default:  return K_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pmm_lane_min.sv
module pmm_lane_min #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  parameter bit SIGNED = 1'b1,
  localparam int DW = LANE_W * LANES
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] la, lb;
    logic              a_lt;
    assign la = a_i[k*LANE_W +: LANE_W];
    assign lb = b_i[k*LANE_W +: LANE_W];
    if (SIGNED) begin : g_s
      assign a_lt = $signed(la) < $signed(lb);
    end else begin : g_u
      assign a_lt = la < lb;
    end
    assign y_o[k*LANE_W +: LANE_W] = a_lt ? la : lb;
  end
endmodule

// File: rtl/pmm_msb_gather.sv
module pmm_msb_gather #(
  parameter int DATA_W = 64,
  parameter int MASK_W = 32,
  localparam int NB = DATA_W / 8
) (
  input  logic [DATA_W-1:0] a_i,
  output logic [MASK_W-1:0] m_o
);
  for (genvar i = 0; i < MASK_W; i++) begin : g_bit
    if (i < NB) begin : g_src
      assign m_o[i] = a_i[8*i+7];
    end else begin : g_zero
      assign m_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/pmm_unit.sv
module pmm_unit
  import pmm_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MASK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic [MASK_W-1:0] mask_o,
  output logic              done_o
);
  localparam int WORDS = DATA_W / 16;
  localparam int BYTES = DATA_W / 8;

  logic [DATA_W-1:0] a_q, b_q, res_q, wmin, bmin;
  logic [MASK_W-1:0] msk_q, gath;
  kind_e             kind_q, in_kind;
  logic              busy_q, done_q, accept;

  assign in_kind = decode_op(op_i);
  assign accept  = start_i && !busy_q;

  pmm_lane_min #(.LANE_W(16), .LANES(WORDS), .SIGNED(1'b1)) i_wmin (
    .a_i(a_q), .b_i(b_q), .y_o(wmin));
  pmm_lane_min #(.LANE_W(8), .LANES(BYTES), .SIGNED(1'b0)) i_bmin (
    .a_i(a_q), .b_i(b_q), .y_o(bmin));
  pmm_msb_gather #(.DATA_W(DATA_W), .MASK_W(MASK_W)) i_gath (
    .a_i(a_i), .m_o(gath));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      kind_q <= K_NONE;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      res_q  <= '0;
      msk_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        // second clock of a minimum: commit from captured operands
        busy_q <= 1'b0;
        done_q <= 1'b1;
        res_q  <= (kind_q == K_SMINW) ? wmin : bmin;
        msk_q  <= '0;
      end
      if (accept) begin
        case (in_kind)
          K_SMINW, K_UMINB: begin
            busy_q <= 1'b1;
            a_q    <= a_i;
            b_q    <= b_i;
            kind_q <= in_kind;
          end
          K_MSKB: begin
            done_q <= 1'b1;
            msk_q  <= gath;
            res_q  <= '0;
          end
          default: begin
            done_q <= 1'b1;
            msk_q  <= '0;
            res_q  <= '0;
          end
        endcase
      end
    end
  end

  assign result_o = res_q;
  assign mask_o   = msk_q;
  assign done_o   = done_q;
endmodule

// File: rtl/pmm_unit_chk.sv
module pmm_unit_chk
  import pmm_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MASK_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [OP_W-1:0]   op_i,
  input logic              busy_i,
  input logic [DATA_W-1:0] result_o,
  input logic [MASK_W-1:0] mask_o,
  input logic              done_o
);
  logic is_min;
  assign is_min = (op_i == OP_SMINW) || (op_i == OP_UMINB);

  a_r4_min_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_i && is_min |=> !done_o ##1 done_o);

  a_r5_mask_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_i && op_i == OP_MSKB |=> done_o && result_o == '0);

  a_r7_unknown_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_i && !is_min && op_i != OP_MSKB
    |=> done_o && result_o == '0 && mask_o == '0);

  a_r3_mask_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_o[MASK_W-1:8] == '0);

  a_r8_pending_completes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> done_o && !busy_i && mask_o == '0);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o) && $stable(mask_o));
endmodule

bind pmm_unit pmm_unit_chk #(.DATA_W(DATA_W), .MASK_W(MASK_W)) i_pmm_unit_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
  .busy_i(busy_q), .result_o(result_o), .mask_o(mask_o), .done_o(done_o));

// File: tb/test_pmm_unit.sv
module test_pmm_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] op_i = 16'h0;
  logic [63:0] a_i = '0, b_i = '0;
  logic [63:0] result_o;
  logic [31:0] mask_o;
  logic        done_o;
  int checks = 0, fails = 0;

  pmm_unit i_pmm_unit (.*);

  always #5 clk_i = ~clk_i;

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic logic [63:0] m_sminw(logic [63:0] a, logic [63:0] b);
    for (int k = 0; k < 4; k++)
      m_sminw[16*k +: 16] = ($signed(a[16*k +: 16]) < $signed(b[16*k +: 16]))
                            ? a[16*k +: 16] : b[16*k +: 16];
  endfunction
  function automatic logic [63:0] m_uminb(logic [63:0] a, logic [63:0] b);
    for (int k = 0; k < 8; k++)
      m_uminb[8*k +: 8] = (a[8*k +: 8] < b[8*k +: 8]) ? a[8*k +: 8] : b[8*k +: 8];
  endfunction
  function automatic logic [31:0] m_mask(logic [63:0] a);
    m_mask = '0;
    for (int i = 0; i < 8; i++) m_mask[i] = a[8*i+7];
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [15:0] op, logic [63:0] a, logic [63:0] b);
    @(negedge clk_i);
    start_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic t_min(string req, logic [15:0] op, logic [63:0] a, logic [63:0] b);
    logic [63:0] exp = (op == 16'h0FEA) ? m_sminw(a, b) : m_uminb(a, b);
    issue(op, a, b);
    chk("R4 no early done", done_o, 0);
    @(negedge clk_i);
    chk("R4 done at second clock", done_o, 1);
    chk(req, result_o, exp);
    chk("R11 mask cleared by min", mask_o, 0);
    @(negedge clk_i);
    chk("R9 single-cycle done", done_o, 0);
    chk("R9 result held", result_o, exp);
  endtask

  task automatic t_mask(logic [63:0] a);
    issue(16'h0FD7, a, ~a);
    chk("R5 done after one clock", done_o, 1);
    chk("R3 mask bits", mask_o, m_mask(a));
    chk("R11 result cleared by mask", result_o, 0);
    @(negedge clk_i);
    chk("R9 single-cycle done", done_o, 0);
  endtask

  task automatic t_unknown(logic [15:0] op);
    issue(op, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    chk("R7 done after one clock", done_o, 1);
    chk("R7 result zero", result_o, 0);
    chk("R7 mask zero", mask_o, 0);
    @(negedge clk_i);
  endtask

  task automatic t_ignore();
    logic [63:0] a = 64'h8000_7FFF_0001_FFFE, b = 64'h0000_8000_0001_0003;
    issue(16'h0FEA, a, b);
    start_i = 1'b1; op_i = 16'h0FD7; a_i = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R8 pending min delivered", result_o, m_sminw(a, b));
    chk("R8 mask not written", mask_o, 0);
    @(negedge clk_i);
    chk("R8 no extra done", done_o, 0);
    chk("R8 mask still zero", mask_o, 0);
  endtask

  task automatic t_reset_mid();
    t_mask(64'h8080_8080_8080_8080);
    issue(16'h0FDA, 64'hFF, 64'h01);
    rst_ni = 1'b0;
    #1;
    chk("R10 result cleared", result_o, 0);
    chk("R10 mask cleared", mask_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 pending dropped", done_o, 0);
    @(negedge clk_i);
    chk("R10 no late done", done_o, 0);
  endtask

  initial begin
    #12;
    chk("R10 reset result", result_o, 0);
    chk("R10 reset mask", mask_o, 0);
    chk("R10 reset done", done_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 and R6: signed word minimum, opcode 0x0FEA
    t_min("R1 signed word min", 16'h0FEA, 64'h8000_7FFF_FFFF_0005, 64'h7FFF_8000_0000_0005);
    t_min("R1 signed mixed", 16'h0FEA, 64'h0001_FFFE_1234_8001, 64'hFFFF_FFFF_1235_8000);
    // R2 and R6: unsigned byte minimum, opcode 0x0FDA
    t_min("R2 unsigned byte min", 16'h0FDA, 64'h80_7F_00_FF_10_20_30_40, 64'h7F_80_FF_00_20_10_30_41);
    t_min("R2 unsigned mixed", 16'h0FDA, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
    // R3, R5 and R6: mask extraction, opcode 0x0FD7
    t_mask(64'h80_00_FF_7F_01_81_00_80);
    t_mask(64'h0);
    t_mask(64'hFFFF_FFFF_FFFF_FFFF);
    t_unknown(16'h0FEB);
    t_unknown(16'h0000);
    t_ignore();
    t_reset_mid();
    t_min("R1 after reset", 16'h0FEA, 64'h0, 64'hFFFF_0000_8000_7FFF);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule